// File: doc/BRIEF.md
# Three-Digit Scan Generator with Dimmer Pulse Width

This block produces the time-multiplexed drive for a display that lights one of three digit groups at a time. It runs from an oscillator-rate clock and cuts time into slots of 2048 clocks. Each slot belongs to one digit. The digits are served in a fixed rotation: one, two, three, then back to one. A full rotation takes 6144 clocks.

In every slot the block raises the enable of the digit that owns the slot. The enable stays low for a fixed two-clock lead-in. It then stays high for twice the 10-bit dimmer code, so the lit fraction of the slot is the code divided by 1024. During the same slot the 88 segment outputs show the bank of display bits that belongs to that digit. The segment bank and the dimmer code are captured only when a slot opens, so a change in the middle of a slot never cuts a pulse short and never alters the pattern shown. A display-enable input turns every segment and digit output off at once. The scan keeps running while the outputs are off, so the display comes back in phase.

Top module: `vfd_scan_dimmer`

## Requirements
- R1: While `rst_ni` is low at a clock edge (synchronous reset), all outputs are low after that edge. The first clock edge with `rst_ni` high opens the slot of digit one at slot clock 0, and that slot shows bank 0.
- R2: Each slot lasts 2048 clocks. Slots serve digits in the order one, two, three and then repeat, so a full rotation is 6144 clocks. `digit_o[k]` belongs to digit k+1.
- R3: With a latched dimmer code DM between 1 and 1022, the owning digit's enable is low at slot clocks 0 and 1. It is high from slot clock 2 through slot clock 2·DM+1, and low for the rest of the slot.
- R4: A latched dimmer code of 0 keeps every digit enable low for the whole slot.
- R5: A dimmer code of 3FFh behaves as 3FEh. The enable is high from slot clock 2 through 2045 and low at clocks 2046 and 2047.
- R6: During the slot of digit k+1 (k = 0, 1, 2), `seg_o[n]` equals `disp_bits_i[n + 88·k]`.
- R7: The segment outputs change only when a slot opens. A bank change in the middle of a slot has no effect until that digit's next slot.
- R8: The dimmer code is sampled only when a slot opens. A change in the middle of a slot neither lengthens nor shortens the pulse of the current slot.
- R9: While `disp_on_i` is low, all segment and digit outputs are low in that same cycle. The scan keeps counting, and output resumes in phase as soon as `disp_on_i` returns high.
- R10: At most one digit enable is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| disp_on_i | input | 1 | Display enable; low forces all outputs low |
| dimmer_i | input | 10 | Dimmer code; on-time is code/1024 of a slot |
| disp_bits_i | input | 264 | Three 88-bit display banks; bank k at bits [88k +: 88] |
| digit_o | output | 3 | Digit enables, bit 0 = digit one |
| seg_o | output | 88 | Segment outputs for the current digit |

## Verification
Two pairs of functions can act in the same cycle. The first pair is blanking and a digit pulse. The display enable is dropped and raised again while a digit is in its lit window, well away from any slot edge. The bench expects all outputs low in the very next sampled cycle and the same digit and bank back in place once the enable returns. The second pair is an input update and the boundary capture. The dimmer code and a segment bank are rewritten in the middle of a slot. The bench judges that the running pulse keeps its old length and the old pattern stays. It then checks that the new values show up exactly at the following slot edge, including the two extreme codes 0 and 3FFh.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
    localparam int unsigned SEG_W_DEF     = 88;
    localparam int unsigned DIGITS_DEF    = 3;
    localparam int unsigned SLOT_CLKS_DEF = 2048;
    localparam int unsigned DIM_W_DEF     = 10;
    localparam int unsigned GAP_CLKS_DEF  = 2;
endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
    parameter int unsigned SLOT_CLKS = 2048,
    parameter int unsigned DIGITS    = 3,
    localparam int unsigned SLOT_W   = $clog2(SLOT_CLKS),
    localparam int unsigned DIG_W    = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic [SLOT_W-1:0] cnt_q_o,
    output logic [DIG_W-1:0]  dig_q_o,
    output logic [SLOT_W-1:0] cnt_nxt_o,
    output logic [DIG_W-1:0]  dig_nxt_o,
    output logic              slot_open_o
);
    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
        logic [DIG_W-1:0]  dig;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic last_clk;

    always_comb begin
        tmr_d    = tmr_q;
        last_clk = (tmr_q.cnt == SLOT_W'(SLOT_CLKS - 1));
        if (last_clk) begin
            tmr_d.cnt = '0;
            if (tmr_q.dig == DIG_W'(DIGITS - 1)) begin
                tmr_d.dig = '0;
            end else begin
                tmr_d.dig = tmr_q.dig + 1'b1;
            end
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    // Reset parks the scan on the final clock of the last digit, so the
    // first edge after release opens digit one at slot clock 0.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tmr_q.cnt <= SLOT_W'(SLOT_CLKS - 1);
            tmr_q.dig <= DIG_W'(DIGITS - 1);
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cnt_q_o     = tmr_q.cnt;
    assign dig_q_o     = tmr_q.dig;
    assign cnt_nxt_o   = tmr_d.cnt;
    assign dig_nxt_o   = tmr_d.dig;
    assign slot_open_o = last_clk;
endmodule

// File: rtl/vfd_dim_window.sv
module vfd_dim_window #(
    parameter int unsigned SLOT_W   = 11,
    parameter int unsigned DIM_W    = 10,
    parameter int unsigned GAP_CLKS = 2,
    localparam int unsigned EW      = SLOT_W + 1,
    localparam int unsigned STEP_SH = SLOT_W - DIM_W
) (
    input  logic [SLOT_W-1:0] cnt_i,
    input  logic [DIM_W-1:0]  dim_i,
    output logic              lit_o
);
    logic [EW-1:0] stop_w;
    logic [EW-1:0] cnt_w;

    // One dimmer step equals 2^STEP_SH clocks of on-time.
    assign stop_w = EW'(GAP_CLKS) + (EW'(dim_i) << STEP_SH);
    assign cnt_w  = EW'(cnt_i);
    assign lit_o  = (cnt_w >= EW'(GAP_CLKS)) && (cnt_w < stop_w);
endmodule

// File: rtl/vfd_bank_mux.sv
module vfd_bank_mux #(
    parameter int unsigned SEG_W  = 88,
    parameter int unsigned DIGITS = 3,
    localparam int unsigned DIG_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic [SEG_W*DIGITS-1:0] bits_i,
    input  logic [DIG_W-1:0]        sel_i,
    output logic [SEG_W-1:0]        seg_o
);
    logic [SEG_W-1:0] part [DIGITS];

    for (genvar k = 0; k < DIGITS; k++) begin : g_bank
        assign part[k] = (sel_i == DIG_W'(k)) ? bits_i[k*SEG_W +: SEG_W] : '0;
    end

    always_comb begin
        seg_o = '0;
        for (int k = 0; k < DIGITS; k++) begin
            seg_o = seg_o | part[k];
        end
    end
endmodule

// File: rtl/vfd_scan_dimmer.sv
module vfd_scan_dimmer
    import vfd_scan_pkg::*;
#(
    parameter int unsigned SEG_W     = SEG_W_DEF,
    parameter int unsigned DIGITS    = DIGITS_DEF,
    parameter int unsigned SLOT_CLKS = SLOT_CLKS_DEF,
    parameter int unsigned DIM_W     = DIM_W_DEF,
    parameter int unsigned GAP_CLKS  = GAP_CLKS_DEF
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    disp_on_i,
    input  logic [DIM_W-1:0]        dimmer_i,
    input  logic [SEG_W*DIGITS-1:0] disp_bits_i,
    output logic [DIGITS-1:0]       digit_o,
    output logic [SEG_W-1:0]        seg_o
);
    localparam int unsigned SLOT_W = $clog2(SLOT_CLKS);
    localparam int unsigned DIG_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    typedef struct packed {
        logic [DIM_W-1:0]  dim;
        logic [SEG_W-1:0]  seg;
        logic [DIGITS-1:0] grid;
    } state_t;

    state_t st_d, st_q;

    logic [SLOT_W-1:0] slot_cnt_q, slot_cnt_nxt;
    logic [DIG_W-1:0]  digit_idx_q, digit_idx_nxt;
    logic              slot_open;
    logic [DIM_W-1:0]  dim_sel;
    logic [DIM_W-1:0]  dim_lat;
    logic [SEG_W-1:0]  bank_seg;
    logic              lit_nxt;

    function automatic logic [DIM_W-1:0] clamp_dim(input logic [DIM_W-1:0] v);
        return (&v) ? (v - DIM_W'(1)) : v;
    endfunction

    vfd_slot_timer #(
        .SLOT_CLKS (SLOT_CLKS),
        .DIGITS    (DIGITS)
    ) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cnt_q_o     (slot_cnt_q),
        .dig_q_o     (digit_idx_q),
        .cnt_nxt_o   (slot_cnt_nxt),
        .dig_nxt_o   (digit_idx_nxt),
        .slot_open_o (slot_open)
    );

    vfd_bank_mux #(
        .SEG_W  (SEG_W),
        .DIGITS (DIGITS)
    ) u_mux (
        .bits_i (disp_bits_i),
        .sel_i  (digit_idx_nxt),
        .seg_o  (bank_seg)
    );

    // Dimmer code for the slot entered at the next edge.
    assign dim_sel = slot_open ? clamp_dim(dimmer_i) : st_q.dim;

    vfd_dim_window #(
        .SLOT_W   (SLOT_W),
        .DIM_W    (DIM_W),
        .GAP_CLKS (GAP_CLKS)
    ) u_window (
        .cnt_i (slot_cnt_nxt),
        .dim_i (dim_sel),
        .lit_o (lit_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.dim = dim_sel;
        if (slot_open) begin
            st_d.seg = bank_seg;
        end
        st_d.grid = lit_nxt ? (DIGITS'(1) << digit_idx_nxt) : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dim_lat = st_q.dim;
    assign seg_o   = st_q.seg  & {SEG_W{disp_on_i}};
    assign digit_o = st_q.grid & {DIGITS{disp_on_i}};
endmodule

// File: rtl/vfd_scan_checker.sv
module vfd_scan_checker #(
    parameter int unsigned SEG_W    = 88,
    parameter int unsigned DIGITS   = 3,
    parameter int unsigned SLOT_W   = 11,
    parameter int unsigned DIG_W    = 2,
    parameter int unsigned DIM_W    = 10,
    parameter int unsigned GAP_CLKS = 2,
    parameter int unsigned STEP     = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              disp_on_i,
    input logic [DIGITS-1:0] digit_o,
    input logic [SEG_W-1:0]  seg_o,
    input logic [SLOT_W-1:0] cnt_i,
    input logic [DIG_W-1:0]  dig_i,
    input logic [DIM_W-1:0]  dim_i
);
    p_one_digit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(digit_o));

    p_blank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !disp_on_i |-> (digit_o == '0 && seg_o == '0));

    p_lead_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(cnt_i) < GAP_CLKS) |-> (digit_o == '0));

    p_lit_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (disp_on_i && dim_i != '0 && int'(cnt_i) >= GAP_CLKS &&
         int'(cnt_i) < GAP_CLKS + int'(dim_i) * STEP) |-> (digit_o != '0));

    p_dark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dim_i == '0) |-> (digit_o == '0));

    p_no_full_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(&dim_i));

    p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i != '0) |-> $stable(dig_i));

    p_seg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i != '0 && disp_on_i && $past(disp_on_i)) |-> $stable(seg_o));

    p_dim_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i != '0) |-> $stable(dim_i));
endmodule

bind vfd_scan_dimmer vfd_scan_checker #(
    .SEG_W    (SEG_W),
    .DIGITS   (DIGITS),
    .SLOT_W   (SLOT_W),
    .DIG_W    (DIG_W),
    .DIM_W    (DIM_W),
    .GAP_CLKS (GAP_CLKS),
    .STEP     (SLOT_CLKS >> DIM_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .disp_on_i (disp_on_i),
    .digit_o   (digit_o),
    .seg_o     (seg_o),
    .cnt_i     (slot_cnt_q),
    .dig_i     (digit_idx_q),
    .dim_i     (dim_lat)
);

// File: tb/vfd_scan_dimmer_bench.sv
`timescale 1ns/1ps
module vfd_scan_dimmer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         disp_on = 1'b1;
    logic [9:0]   dimmer = 10'd3;
    logic [263:0] bits;
    logic [2:0]   digit;
    logic [87:0]  seg;

    localparam logic [87:0] B0  = 88'hA5A5_0F0F_1234_5678_9ABC_DE;
    localparam logic [87:0] B1  = 88'h0123_4567_89AB_CDEF_F0E1_D2;
    localparam logic [87:0] B2  = 88'hFEDC_BA98_7654_3210_8001_7E;
    localparam logic [87:0] NB0 = 88'h5A5A_F0F0_EDCB_A987_6543_21;

    int checks = 0;
    int failures = 0;
    int pos = -1;
    int overlap = 0;

    typedef struct {
        int         p;
        string      req;
        logic [2:0] dig;
        logic [87:0] sg;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    vfd_scan_dimmer u_vfd_scan_dimmer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .disp_on_i   (disp_on),
        .dimmer_i    (dimmer),
        .disp_bits_i (bits),
        .digit_o     (digit),
        .seg_o       (seg)
    );

    task automatic expect_at(input int p, input string r, input logic [2:0] d, input logic [87:0] s);
        item_t it;
        it.p = p; it.req = r; it.dig = d; it.sg = s;
        q.push_back(it);
    endtask

    task automatic judge(input string r, input logic ok, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", r, what);
        end
    endtask

    // Wait until the edge after scan position p, then drive shortly after it.
    task automatic goto(input int p);
        while (pos != p) @(posedge clk);
        #2;
    endtask

    // Monitor: tracks the scan position and compares queued expectations.
    initial begin
        forever begin
            logic r;
            @(posedge clk);
            r = rst_n;
            @(negedge clk);
            if (!r) begin
                pos = -1;
            end else begin
                pos++;
                if ($countones(digit) > 1) overlap++;
                while (q.size() > 0 && q[0].p <= pos) begin
                    item_t it;
                    it = q.pop_front();
                    if (it.p < pos) begin
                        judge(it.req, 1'b0, $sformatf("missed sample at pos %0d", it.p));
                    end else begin
                        judge(it.req, digit == it.dig,
                              $sformatf("pos %0d digit actual=%b expected=%b", pos, digit, it.dig));
                        judge(it.req, seg == it.sg,
                              $sformatf("pos %0d seg actual=%h expected=%h", pos, seg, it.sg));
                    end
                end
            end
        end
    end

    initial begin
        bits = {B2, B1, B0};
        // Expected items, ascending in scan position.
        expect_at(0,     "R1", 3'b000, B0);
        expect_at(1,     "R3", 3'b000, B0);
        expect_at(2,     "R3", 3'b001, B0);
        expect_at(7,     "R3", 3'b001, B0);
        expect_at(8,     "R3", 3'b000, B0);
        expect_at(2047,  "R2", 3'b000, B0);
        expect_at(2048,  "R6", 3'b000, B1);
        expect_at(2050,  "R2", 3'b010, B1);
        expect_at(4098,  "R2", 3'b100, B2);
        expect_at(6146,  "R2", 3'b001, B0);
        expect_at(6600,  "R7", 3'b000, B0);
        expect_at(8192,  "R6", 3'b000, B1);
        expect_at(8194,  "R8", 3'b010, B1);
        expect_at(8692,  "R8", 3'b000, B1);
        expect_at(10241, "R5", 3'b000, B2);
        expect_at(10242, "R5", 3'b100, B2);
        expect_at(12285, "R5", 3'b100, B2);
        expect_at(12286, "R5", 3'b000, B2);
        expect_at(12288, "R7", 3'b000, NB0);
        expect_at(12290, "R8", 3'b001, NB0);
        expect_at(14333, "R5", 3'b001, NB0);
        expect_at(14338, "R4", 3'b000, B1);
        expect_at(15000, "R4", 3'b000, B1);
        expect_at(16386, "R3", 3'b100, B2);
        expect_at(16482, "R9", 3'b000, '0);
        expect_at(16600, "R9", 3'b000, '0);
        expect_at(16602, "R9", 3'b100, B2);
        expect_at(17407, "R3", 3'b100, B2);
        expect_at(17408, "R3", 3'b000, B2);
        expect_at(18434, "R2", 3'b001, NB0);

        fork
            begin
                repeat (3) @(negedge clk);
                judge("R1", digit == 3'b000, $sformatf("reset digit actual=%b expected=000", digit));
                judge("R1", seg == '0, $sformatf("reset seg actual=%h expected=0", seg));
                @(posedge clk); #2;
                rst_n = 1'b1;
                goto(6500);  bits[87:0] = NB0;     // mid-slot bank change (R7)
                goto(8300);  dimmer = 10'h3FF;     // mid-slot dimmer change (R8, R5)
                goto(12400); dimmer = 10'h000;     // R4
                goto(15500); dimmer = 10'h1FF;     // R3 half duty
                goto(16480); disp_on = 1'b0;       // blank inside lit window (R9)
                goto(16600); disp_on = 1'b1;
                while (q.size() > 0) @(posedge clk);
                @(posedge clk);
            end
            begin
                repeat (200000) @(posedge clk);
                judge("watchdog", 1'b0, "run hung actual=timeout expected=done");
            end
        join_any
        disable fork;
        judge("R10", overlap == 0, $sformatf("overlapping enables actual=%0d expected=0", overlap));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule